// File: doc/BRIEF.md
# General-Purpose I/O Bank with Pin Interrupts

This block is one bank of 32 general-purpose pins that sits behind a simple 32-bit register bus. Software uses it to read the level of every pin and to drive output values with their enables. It also sets a pull resistor for each pin, driven out as pad-control signals.

Each pin can also raise an interrupt. Per pin, three independent configuration bits choose the trigger:
- level or edge sensing;
- single edge or both edges;
- the active polarity.

Detected events are latched in a raw status register. A masked view shows the raw status ANDed with a per-pin enable. Software acknowledges an event by writing ones to a clear register. A single registered, active-high line tells the host that at least one enabled pin has latched an event.

Pin inputs are sampled through a two-flop synchronizer. Both the readable input register and the trigger logic see only the synchronized value. A bus write takes effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the following all read zero: every register, the pad outputs `pin_out`, `pin_oe`, `pull_en` and `pull_up`, the raw status and `irq`.
- R2: Offset 0x00 returns the pins after two synchronizer stages. A pin change driven before edge k is visible after edge k+1 and not after edge k. Writes to 0x00 are ignored.
- R3: The register at 0x04 drives `pin_out` and the register at 0x08 drives `pin_oe`, where bit n belongs to pin n and 1 means drive. Both read back their written value.
- R4: Edge sensing applies to a pin whose bit is 0 in the type register (0x0C) and 0 in the dual-edge register (0x10). On such a pin, polarity bit 1 (register 0x14) latches status on a rising edge only, and polarity bit 0 latches it on a falling edge only.
- R5: An edge-sensed pin whose dual-edge bit is 1 latches status on both rising and falling edges, whatever its polarity bit.
- R6: A pin with type bit 1 is level sensed. Its status is set every cycle in which the synchronized level equals its polarity bit, so a clear while the level is active leaves the status set.
- R7: Offset 0x1C reads the raw status. Offset 0x20 reads the raw status ANDed with the enable register at 0x18, where 1 means enabled.
- R8: A write to 0x24 clears exactly the status bits written as 1. The other status bits keep their value.
- R9: When a new qualifying event and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: `irq` is the OR of the masked status bits, delayed by one register. It rises one edge after the status bit is latched and falls one edge after the status bit is cleared.
- R11: The register at 0x34 drives `pull_up`, where 1 selects pull-up and 0 pull-down. The register at 0x38 drives `pull_en`, where 0 means no pull. Both read back.
- R12: Offsets outside the register set, including 0x24, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| pull_en | output | 32 | Pull resistor enable per pin |
| pull_up | output | 32 | Pull direction per pin, 1 = up |
| irq | output | 1 | Combined interrupt to the host, active high |

## Verification
The assertions assume that `pin_in` may change at any time. Only the synchronized copy is related to status, so the properties are written in terms of the internal event and clear vectors rather than the raw pads.

The assertions also assume a well-formed bus, with no write in a reset cycle whose effect must survive. The stimulus meets this by driving the pins and bus signals only at falling clock edges and by holding reset across several edges before any access.

The stimulus also waits long enough for each pin change to pass the synchronizer before it checks status. It deliberately lines up one clear write with the cycle in which a synchronized edge is detected, to exercise that collision.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PIN_COUNT = 32;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int SYNC_LEN  = 2;

    typedef logic [PIN_COUNT-1:0] pin_vec_t;

    // Register offsets (byte addresses)
    localparam logic [ADDR_W-1:0] OFS_DIN     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DOUT    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DRV     = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SENSE   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_BOTH    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_POL     = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN     = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_MSK     = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_PULLDIR = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_PULLON  = 8'h38;

    // Writable per-pin configuration
    typedef struct packed {
        pin_vec_t drive_val;
        pin_vec_t drive_en;
        pin_vec_t lvl_mode;
        pin_vec_t both_edges;
        pin_vec_t active_hi;
        pin_vec_t irq_en;
        pin_vec_t pull_dir;
        pin_vec_t pull_on;
    } gpio_cfg_t;

    // Edge hit for one pin: both edges, or the edge matching polarity
    function automatic logic edge_hit(input logic cur, input logic prev,
                                      input logic both, input logic hi);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (both)
            return rise | fall;
        return hi ? rise : fall;
    endfunction

    // Level hit for one pin: level equals active polarity
    function automatic logic level_hit(input logic cur, input logic hi);
        return ~(cur ^ hi);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int W = PIN_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_now,
    input  logic [W-1:0] lvl_mode,
    input  logic [W-1:0] both_edges,
    input  logic [W-1:0] active_hi,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] set_vec,
    output logic [W-1:0] stat_raw
);

    logic [W-1:0] lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) lvl_prev <= '0;
        else     lvl_prev <= lvl_now;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            assign set_vec[i] = lvl_mode[i]
                ? level_hit(lvl_now[i], active_hi[i])
                : edge_hit(lvl_now[i], lvl_prev[i], both_edges[i], active_hi[i]);
        end
    endgenerate

    // A new event in the same cycle as its clear keeps the bit set
    always_ff @(posedge clk) begin
        if (rst) stat_raw <= '0;
        else     stat_raw <= set_vec | (stat_raw & ~clr_mask);
    end

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  pin_vec_t          din_sync,
    input  pin_vec_t          stat_raw,
    output gpio_cfg_t         cfg,
    output pin_vec_t          clr_mask
);

    pin_vec_t wr_bits;
    assign wr_bits = bus_wdata[PIN_COUNT-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_DOUT:    cfg.drive_val  <= wr_bits;
                OFS_DRV:     cfg.drive_en   <= wr_bits;
                OFS_SENSE:   cfg.lvl_mode   <= wr_bits;
                OFS_BOTH:    cfg.both_edges <= wr_bits;
                OFS_POL:     cfg.active_hi  <= wr_bits;
                OFS_IEN:     cfg.irq_en     <= wr_bits;
                OFS_PULLDIR: cfg.pull_dir   <= wr_bits;
                OFS_PULLON:  cfg.pull_on    <= wr_bits;
                default:     ;
            endcase
        end
    end

    assign clr_mask = (bus_wr && bus_addr == OFS_ACK) ? wr_bits : '0;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DIN:     bus_rdata[PIN_COUNT-1:0] = din_sync;
            OFS_DOUT:    bus_rdata[PIN_COUNT-1:0] = cfg.drive_val;
            OFS_DRV:     bus_rdata[PIN_COUNT-1:0] = cfg.drive_en;
            OFS_SENSE:   bus_rdata[PIN_COUNT-1:0] = cfg.lvl_mode;
            OFS_BOTH:    bus_rdata[PIN_COUNT-1:0] = cfg.both_edges;
            OFS_POL:     bus_rdata[PIN_COUNT-1:0] = cfg.active_hi;
            OFS_IEN:     bus_rdata[PIN_COUNT-1:0] = cfg.irq_en;
            OFS_RAW:     bus_rdata[PIN_COUNT-1:0] = stat_raw;
            OFS_MSK:     bus_rdata[PIN_COUNT-1:0] = stat_raw & cfg.irq_en;
            OFS_PULLDIR: bus_rdata[PIN_COUNT-1:0] = cfg.pull_dir;
            OFS_PULLON:  bus_rdata[PIN_COUNT-1:0] = cfg.pull_on;
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] pull_en,
    output logic [PIN_COUNT-1:0] pull_up,
    output logic                 irq
);

    pin_vec_t  din_sync;
    pin_vec_t  stat_raw;
    pin_vec_t  set_vec;
    pin_vec_t  clr_mask;
    gpio_cfg_t cfg;

    gpio_pin_sync #(.W(PIN_COUNT), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (din_sync)
    );

    gpio_reg_bank u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .din_sync  (din_sync),
        .stat_raw  (stat_raw),
        .cfg       (cfg),
        .clr_mask  (clr_mask)
    );

    gpio_irq_detect #(.W(PIN_COUNT)) u_detect (
        .clk        (clk),
        .rst        (rst),
        .lvl_now    (din_sync),
        .lvl_mode   (cfg.lvl_mode),
        .both_edges (cfg.both_edges),
        .active_hi  (cfg.active_hi),
        .clr_mask   (clr_mask),
        .set_vec    (set_vec),
        .stat_raw   (stat_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(stat_raw & cfg.irq_en);
    end

    assign pin_out = cfg.drive_val;
    assign pin_oe  = cfg.drive_en;
    assign pull_en = cfg.pull_on;
    assign pull_up = cfg.pull_dir;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         irq,
    input logic [W-1:0] stat_raw,
    input logic [W-1:0] irq_en,
    input logic [W-1:0] set_vec,
    input logic [W-1:0] clr_mask
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq && stat_raw == '0)); // R1

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
        (|(stat_raw & irq_en)) |=> irq); // R10

    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
        !(|(stat_raw & irq_en)) |=> !irq); // R10

    AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_raw != '0) |=> (($past(stat_raw) & ~stat_raw & ~$past(clr_mask)) == '0)); // R8

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((stat_raw & $past(set_vec)) == $past(set_vec))); // R9

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(gpio_irq_pkg::PIN_COUNT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .stat_raw (stat_raw),
    .irq_en   (cfg.irq_en),
    .set_vec  (set_vec),
    .clr_mask (clr_mask)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;

    localparam logic [7:0] A_DIN  = 8'h00, A_DOUT = 8'h04, A_OE   = 8'h08;
    localparam logic [7:0] A_TYPE = 8'h0C, A_DUAL = 8'h10, A_POL  = 8'h14;
    localparam logic [7:0] A_IEN  = 8'h18, A_RAW  = 8'h1C, A_MSK  = 8'h20;
    localparam logic [7:0] A_CLR  = 8'h24, A_PSEL = 8'h34, A_PEN  = 8'h38;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pull_en, pull_up;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_irq_bank u_gpio_irq_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
        .pull_up(pull_up), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        chk(req, v, exp);
    endtask

    task automatic clear_all();
        bus_write(A_CLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        rd_chk("R1 dout", A_DOUT, 0);
        rd_chk("R1 oe", A_OE, 0);
        rd_chk("R1 type", A_TYPE, 0);
        rd_chk("R1 dual", A_DUAL, 0);
        rd_chk("R1 pol", A_POL, 0);
        rd_chk("R1 ien", A_IEN, 0);
        rd_chk("R1 raw", A_RAW, 0);
        rd_chk("R1 psel", A_PSEL, 0);
        rd_chk("R1 pen", A_PEN, 0);
        chk("R1 pads", pin_out | pin_oe | pull_en | pull_up, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_data_in();
        @(negedge clk);
        pin_in = 32'hA5C3_0F18;
        wait_cyc(1);
        rd_chk("R2 one stage", A_DIN, 0);
        wait_cyc(1);
        rd_chk("R2 two stages", A_DIN, 32'hA5C3_0F18);
        bus_write(A_DIN, 32'h0000_FFFF);
        rd_chk("R2 write ignored", A_DIN, 32'hA5C3_0F18);
        pin_in = 0;
        wait_cyc(4);
        clear_all();
        rd_chk("R8 clear all", A_RAW, 0);
    endtask

    task automatic t_outputs();
        bus_write(A_DOUT, 32'h1234_5678);
        bus_write(A_OE, 32'h0F0F_00FF);
        chk("R3 pin_out", pin_out, 32'h1234_5678);
        chk("R3 pin_oe", pin_oe, 32'h0F0F_00FF);
        rd_chk("R3 dout rb", A_DOUT, 32'h1234_5678);
        rd_chk("R3 oe rb", A_OE, 32'h0F0F_00FF);
    endtask

    task automatic t_pull();
        bus_write(A_PSEL, 32'hDEAD_0001);
        bus_write(A_PEN, 32'h00FF_FF00);
        chk("R11 pull_up", pull_up, 32'hDEAD_0001);
        chk("R11 pull_en", pull_en, 32'h00FF_FF00);
        rd_chk("R11 psel rb", A_PSEL, 32'hDEAD_0001);
        rd_chk("R11 pen rb", A_PEN, 32'h00FF_FF00);
    endtask

    task automatic t_unused();
        rd_chk("R12 0x24", A_CLR, 0);
        rd_chk("R12 0x28", 8'h28, 0);
        rd_chk("R12 0x30", 8'h30, 0);
        rd_chk("R12 0x3C", 8'h3C, 0);
        rd_chk("R12 0x80", 8'h80, 0);
    endtask

    task automatic t_edge();
        bus_write(A_POL, 32'h1);
        pin_in = 32'h3;
        wait_cyc(5);
        rd_chk("R4 rising only", A_RAW, 32'h1);
        clear_all();
        pin_in = 0;
        wait_cyc(5);
        rd_chk("R4 falling only", A_RAW, 32'h2);
        clear_all();
        rd_chk("R8 cleared", A_RAW, 0);
    endtask

    task automatic t_dual();
        bus_write(A_DUAL, 32'h4);
        pin_in = 32'h4;
        wait_cyc(5);
        rd_chk("R5 dual rise", A_RAW, 32'h4);
        clear_all();
        pin_in = 0;
        wait_cyc(5);
        rd_chk("R5 dual fall", A_RAW, 32'h4);
        clear_all();
        bus_write(A_DUAL, 0);
    endtask

    task automatic t_level();
        bus_write(A_POL, 32'h9);
        bus_write(A_TYPE, 32'h8);
        pin_in = 32'h8;
        wait_cyc(5);
        rd_chk("R6 level high", A_RAW, 32'h8);
        bus_write(A_CLR, 32'h8);
        rd_chk("R6 reasserts", A_RAW, 32'h8);
        pin_in = 0;
        wait_cyc(5);
        bus_write(A_CLR, 32'h8);
        rd_chk("R6 inactive clears", A_RAW, 0);
        bus_write(A_POL, 32'h1);
        wait_cyc(1);
        rd_chk("R6 active low", A_RAW, 32'h8);
        bus_write(A_TYPE, 0);
        clear_all();
        rd_chk("R6 back to edge", A_RAW, 0);
    endtask

    task automatic t_mask_irq();
        bus_write(A_POL, 32'h10);
        bus_write(A_IEN, 32'h10);
        pin_in = 32'h2;
        wait_cyc(5);
        pin_in = 0;
        wait_cyc(5);
        @(negedge clk);
        pin_in = 32'h10;
        wait_cyc(3);
        rd_chk("R10 status latched", A_RAW, 32'h12);
        chk("R10 irq not yet", {31'b0, irq}, 0);
        wait_cyc(1);
        chk("R10 irq one later", {31'b0, irq}, 1);
        rd_chk("R7 masked", A_MSK, 32'h10);
        bus_write(A_CLR, 32'h10);
        rd_chk("R8 only bit4", A_RAW, 32'h2);
        chk("R10 irq held", {31'b0, irq}, 1);
        wait_cyc(1);
        chk("R10 irq drops", {31'b0, irq}, 0);
        bus_write(A_IEN, 32'h2);
        wait_cyc(1);
        chk("R10 irq via enable", {31'b0, irq}, 1);
        rd_chk("R7 masked bit1", A_MSK, 32'h2);
        pin_in = 0;
        wait_cyc(4);
        clear_all();
        bus_write(A_IEN, 0);
        wait_cyc(1);
        chk("R10 irq idle", {31'b0, irq}, 0);
    endtask

    task automatic t_set_wins();
        bus_write(A_POL, 32'h20);
        clear_all();
        @(negedge clk);
        pin_in = 32'h20;
        wait_cyc(2);
        bus_write(A_CLR, 32'h20);
        rd_chk("R9 set wins", A_RAW, 32'h20);
        bus_write(A_CLR, 32'h20);
        rd_chk("R9 later clear", A_RAW, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);
        t_reset();
        t_data_in();
        t_outputs();
        t_pull();
        t_unused();
        t_edge();
        t_dual();
        t_level();
        t_mask_irq();
        t_set_wins();
        finish_run();
    end

endmodule